// File: doc/BRIEF.md
# Cycle-by-Cycle Over-Current Gate Pair

This block sits between a switching timing generator and two gate drivers of a two-stage power converter. Each stage has a raw gate request from the timing generator, a digital over-current flag from an external comparator, and a strobe that marks the start of that stage's switching period. The block forwards each request as a registered drive signal. An over-current flag cuts the pulse short and keeps the drive off until the stage's next period starts.

Both stages use the same channel logic, which is built twice. The first stage (channel A) acts on its flag at once. The second stage (channel B) has a leading-edge blanking window. For a set number of clocks after each turn-on of its request, channel B ignores its flag, so the switching spike at turn-on does not end the pulse. Comparator thresholds and analog filtering lie outside the block. The channel B flag stands for its sense input rising above about 1 V. The channel A flag stands for its sense input falling below about -1.3 V. The blanking length is a parameter counted in clocks. Its default of 50 clocks is 250 ns at a 5 ns clock.

Top module: `ocp_gate_pair`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after reset, both drive outputs are 0 and no channel is latched off.
- R2: With no effective flag and no latch set, each drive output equals that channel's request from one clock earlier.
- R3: A flag that acts on a channel (on channel A, any high flag) drives that channel's output low on the next clock. The output stays low for the rest of the period, even after the flag and the request return to normal.
- R4: Only a period strobe clears the off latch. In the cycle after a strobe the latch is clear, and later pulses in the new period pass through normally.
- R5: When a strobe and an effective flag fall in the same cycle, the strobe wins for the latch, which ends up clear. The live flag still holds the output low for that one cycle. If the flag is gone in the next cycle, the drive follows the request again.
- R6: On channel A, a flag that is already high when a period starts and the request rises keeps the drive low for the whole period. The pulse never starts.
- R7: On channel B, the flag is ignored for BLANK_CYC clocks after each rising edge of the request. This window includes the rising-edge cycle itself. A flag pulse that ends inside the window never shortens the output.
- R8: On channel B, a flag in the first cycle after the blanking window ends, or in any later cycle, turns the drive off on the next clock. The drive then stays off until the next strobe.
- R9: The blanking window restarts on every rising edge of channel B's request, including a second turn-on within one period.
- R10: The two channels are independent. A flag, strobe or request on one channel never changes the other channel's drive.
- R11: A low request gives a low drive on the next clock, whatever the flag and latch state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| a_req_i | input | 1 | Channel A raw gate request |
| a_oc_i | input | 1 | Channel A over-current flag |
| a_period_i | input | 1 | Channel A period-start strobe |
| a_drive_o | output | 1 | Channel A gated drive |
| b_req_i | input | 1 | Channel B raw gate request |
| b_oc_i | input | 1 | Channel B over-current flag |
| b_period_i | input | 1 | Channel B period-start strobe |
| b_drive_o | output | 1 | Channel B gated drive |

## Verification
The embedded properties check on every cycle that a strobe clears the latch and that nothing else clears it. They also check that an effective flag or a low request forces the drive low one clock later, that a drive pulse only follows a request, that each rising request opens a blanking window, and that a flag inside that window never sets the latch. Only the directed scenarios can show the longer behaviours. These are the exact edges of the blanking window counted in clocks, a whole period held off by a flag present at its start, strobe priority together with the one-cycle recovery that follows, blanking restarting on a second turn-on, and the two channels staying independent.

// File: rtl/ocp_gate_pkg.sv
package ocp_gate_pkg;

    // Registered state of the off latch and gate stage
    typedef struct packed {
        logic trip;
        logic drive;
    } gate_state_t;

    // Width for a down-counter that must hold values up to n
    function automatic int unsigned cnt_width(input int unsigned n);
        int unsigned w;
        w = 1;
        while ((1 << w) <= n) begin
            w = w + 1;
        end
        return w;
    endfunction

endpackage

// File: rtl/ocp_blank_window.sv
module ocp_blank_window
    import ocp_gate_pkg::*;
#(
    parameter int unsigned BLANK_CYC = 50
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    output logic blank_o
);

    localparam int unsigned CW = cnt_width(BLANK_CYC);
    localparam logic [CW-1:0] RELOAD = CW'(BLANK_CYC - 1);

    typedef struct packed {
        logic          req_prev;
        logic [CW-1:0] left;
    } blank_state_t;

    blank_state_t st_d, st_q;
    logic         rise;

    always_comb begin
        st_d          = st_q;
        rise          = req_i && !st_q.req_prev;
        st_d.req_prev = req_i;
        if (!req_i) begin
            st_d.left = '0;
        end else if (rise) begin
            st_d.left = RELOAD;
        end else if (st_q.left != '0) begin
            st_d.left = st_q.left - 1'b1;
        end
        blank_o = req_i && (rise || (st_q.left != '0));
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R9
    rise_opens_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(req_i) |-> blank_o);

    // R7
    blank_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.left <= RELOAD);

    // R7
    blank_contig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (blank_o && !$rose(req_i)) |-> $past(blank_o));

endmodule

// File: rtl/ocp_trip_latch.sv
module ocp_trip_latch
    import ocp_gate_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    input  logic oc_eff_i,
    input  logic period_i,
    output logic drive_o,
    output logic trip_o
);

    gate_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Strobe has priority over a coincident flag
        if (period_i) begin
            st_d.trip = 1'b0;
        end else if (oc_eff_i) begin
            st_d.trip = 1'b1;
        end
        // A live flag also blocks the drive in the strobe cycle
        st_d.drive = req_i && !st_d.trip && !oc_eff_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign drive_o = st_q.drive;
    assign trip_o  = st_q.trip;

    // R4
    strobe_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        period_i |=> !trip_o);

    // R3
    trip_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trip_o && !period_i) |=> trip_o);

    // R3
    flag_cuts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        oc_eff_i |=> !drive_o);

    // R11
    req_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_i |=> !drive_o);

    // R2
    drive_has_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        drive_o |-> $past(req_i));

endmodule

// File: rtl/ocp_channel.sv
module ocp_channel
    import ocp_gate_pkg::*;
#(
    parameter bit          BLANK_EN  = 1'b0,
    parameter int unsigned BLANK_CYC = 50
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    input  logic oc_i,
    input  logic period_i,
    output logic drive_o
);

    logic blank;
    logic oc_eff;
    logic trip;

    generate
        if (BLANK_EN) begin : g_blank
            ocp_blank_window #(
                .BLANK_CYC(BLANK_CYC)
            ) blank_i (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .req_i  (req_i),
                .blank_o(blank)
            );
        end else begin : g_noblank
            assign blank = 1'b0;
        end
    endgenerate

    assign oc_eff = oc_i && !blank;

    ocp_trip_latch latch_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .req_i   (req_i),
        .oc_eff_i(oc_eff),
        .period_i(period_i),
        .drive_o (drive_o),
        .trip_o  (trip)
    );

    // R7
    blank_masks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (blank && !trip && !period_i) |=> !trip);

    // R1
    reset_state_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (!drive_o && !trip));

endmodule

// File: rtl/ocp_gate_pair.sv
module ocp_gate_pair #(
    parameter int unsigned BLANK_CYC = 50
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic a_req_i,
    input  logic a_oc_i,
    input  logic a_period_i,
    output logic a_drive_o,
    input  logic b_req_i,
    input  logic b_oc_i,
    input  logic b_period_i,
    output logic b_drive_o
);

    // Channel A: immediate limit, no blanking
    ocp_channel #(
        .BLANK_EN (1'b0),
        .BLANK_CYC(BLANK_CYC)
    ) chan_a_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .req_i   (a_req_i),
        .oc_i    (a_oc_i),
        .period_i(a_period_i),
        .drive_o (a_drive_o)
    );

    // Channel B: leading-edge blanking after each turn-on
    ocp_channel #(
        .BLANK_EN (1'b1),
        .BLANK_CYC(BLANK_CYC)
    ) chan_b_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .req_i   (b_req_i),
        .oc_i    (b_oc_i),
        .period_i(b_period_i),
        .drive_o (b_drive_o)
    );

    // R10
    a_isolated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (a_oc_i && !b_oc_i && b_req_i && $past(b_drive_o) && !b_period_i) |=> b_drive_o);

endmodule

// File: tb/ocp_gate_pair_tb.sv
module ocp_gate_pair_tb_top;

    localparam int unsigned BLANK_CYC = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_req = 1'b0, a_oc = 1'b0, a_per = 1'b0;
    logic b_req = 1'b0, b_oc = 1'b0, b_per = 1'b0;
    logic a_drv, b_drv;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    ocp_gate_pair #(.BLANK_CYC(BLANK_CYC)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .a_req_i(a_req), .a_oc_i(a_oc), .a_period_i(a_per), .a_drive_o(a_drv),
        .b_req_i(b_req), .b_oc_i(b_oc), .b_period_i(b_per), .b_drive_o(b_drv)
    );

    // Advance one edge; sample 1 ns after it
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic b_new_period();
        b_req = 1'b0; b_oc = 1'b0; b_per = 1'b1; tick();
        b_per = 1'b0;
    endtask

    task automatic a_new_period();
        a_req = 1'b0; a_oc = 1'b0; a_per = 1'b1; tick();
        a_per = 1'b0;
    endtask

    task automatic t_reset();
        chk(a_drv, 1'b0, "R1 A drive in reset");
        chk(b_drv, 1'b0, "R1 B drive in reset");
        rst_n = 1'b1;
        tick();
        chk(a_drv, 1'b0, "R1 A drive after reset");
        chk(b_drv, 1'b0, "R1 B drive after reset");
    endtask

    task automatic t_pass();
        a_req = 1'b1; b_req = 1'b1; tick();
        chk(a_drv, 1'b1, "R2 A follows request");
        chk(b_drv, 1'b1, "R2 B follows request");
        a_req = 1'b0; b_req = 1'b0; a_oc = 1'b1; tick();
        chk(a_drv, 1'b0, "R11 A low request");
        chk(b_drv, 1'b0, "R11 B low request");
        a_new_period();
        b_new_period();
    endtask

    task automatic t_trip_a();
        a_req = 1'b1; tick();
        tick();
        a_oc = 1'b1; tick();
        chk(a_drv, 1'b0, "R3 A cut one clock after flag");
        a_oc = 1'b0;
        begin
            logic bad = 1'b0;
            for (int i = 0; i < 6; i++) begin
                tick();
                if (a_drv) bad = 1'b1;
            end
            a_req = 1'b0; tick();
            a_req = 1'b1; tick();
            if (a_drv) bad = 1'b1;
            chk(bad, 1'b0, "R3 A held off for rest of period");
        end
        a_req = 1'b0; a_per = 1'b1; tick();
        a_per = 1'b0; a_req = 1'b1; tick();
        chk(a_drv, 1'b1, "R4 A released by strobe");
        a_req = 1'b0; tick();
    endtask

    task automatic t_strobe_prio();
        a_req = 1'b1; a_oc = 1'b1; tick();
        a_oc = 1'b0; tick();
        chk(a_drv, 1'b0, "R5 A latched before strobe");
        a_per = 1'b1; a_oc = 1'b1; tick();
        chk(a_drv, 1'b0, "R5 live flag blocks strobe cycle");
        a_per = 1'b0; a_oc = 1'b0; tick();
        chk(a_drv, 1'b1, "R5 strobe won over coincident flag");
        a_new_period();
    endtask

    task automatic t_start_flag();
        logic bad = 1'b0;
        a_per = 1'b1; a_req = 1'b1; a_oc = 1'b1; tick();
        if (a_drv) bad = 1'b1;
        a_per = 1'b0; tick();
        if (a_drv) bad = 1'b1;
        a_oc = 1'b0;
        for (int i = 0; i < 8; i++) begin
            tick();
            if (a_drv) bad = 1'b1;
        end
        chk(bad, 1'b0, "R6 pulse never starts");
        a_new_period();
    endtask

    task automatic t_blank_short();
        logic bad = 1'b0;
        b_new_period();
        b_req = 1'b1; tick();
        for (int i = 1; i < 70; i++) begin
            b_oc = (i >= 10 && i < 13) || (i >= 40 && i < 49);
            tick();
            if (!b_drv) bad = 1'b1;
        end
        b_oc = 1'b0;
        chk(bad, 1'b0, "R7 short flag pulses inside window never truncate");
    endtask

    task automatic t_blank_edge();
        logic bad = 1'b0;
        b_new_period();
        b_req = 1'b1; b_oc = 1'b1; tick();
        if (!b_drv) bad = 1'b1;
        for (int i = 1; i < BLANK_CYC; i++) begin
            tick();
            if (!b_drv) bad = 1'b1;
        end
        chk(bad, 1'b0, "R7 flag ignored through last blanked cycle");
        tick();
        chk(b_drv, 1'b0, "R8 flag acts in first cycle after window");
        b_oc = 1'b0;
        bad = 1'b0;
        for (int i = 0; i < 5; i++) begin
            tick();
            if (b_drv) bad = 1'b1;
        end
        b_req = 1'b0; tick();
        b_req = 1'b1; tick();
        if (b_drv) bad = 1'b1;
        chk(bad, 1'b0, "R8 B held off until strobe");
        b_new_period();
        b_req = 1'b1; tick();
        chk(b_drv, 1'b1, "R4 B released by strobe");
    endtask

    task automatic t_reblank();
        logic bad = 1'b0;
        for (int i = 0; i < BLANK_CYC + 5; i++) tick();
        b_req = 1'b0; tick();
        b_req = 1'b1; tick();
        for (int i = 0; i < 4; i++) tick();
        b_oc = 1'b1;
        for (int i = 0; i < 10; i++) begin
            tick();
            if (!b_drv) bad = 1'b1;
        end
        b_oc = 1'b0;
        chk(bad, 1'b0, "R9 second turn-on reopens window");
        b_new_period();
    endtask

    task automatic t_indep();
        logic bad = 1'b0;
        a_new_period();
        b_new_period();
        a_req = 1'b1; b_req = 1'b1; tick();
        a_oc = 1'b1; tick();
        chk(a_drv, 1'b0, "R10 A tripped");
        chk(b_drv, 1'b1, "R10 B unaffected by A flag");
        a_oc = 1'b0;
        for (int i = 0; i < BLANK_CYC + 2; i++) tick();
        b_oc = 1'b1; a_per = 1'b1; tick();
        chk(b_drv, 1'b0, "R10 B tripped");
        a_per = 1'b0; b_oc = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tick();
            if (!a_drv) bad = 1'b1;
        end
        b_per = 1'b1; a_req = 1'b1; tick();
        if (!a_drv) bad = 1'b1;
        b_per = 1'b0;
        chk(bad, 1'b0, "R10 A unaffected by B flag and strobe");
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_run++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
                $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        tick();
        tick();
        t_reset();
        t_pass();
        t_trip_a();
        t_strobe_prio();
        t_start_flag();
        t_blank_short();
        t_blank_edge();
        t_reblank();
        t_indep();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule